// File: doc/BRIEF.md
# Power Control and Status Register Unit

This unit holds the software-visible state of a chip power manager in two 32-bit registers on a simple request/ready bus. The control word sits at byte offset 0x00 and the status word at 0x04. The control word drives the low-power regulator select, the deep-sleep power-down select, the supply detector enable and level, the backup-domain write permission and three converter enables. It also accepts two one-shot clear commands. The status word reports a wakeup flag, a standby flag, the live detector output and a reference-ready indication, and it holds the enables of three wakeup pins.

Each field has its own reset rule. The unit sees three synchronous active-high reset kinds: a power-on/power-down reset, a system reset and a standby-exit reset. The standby flag survives everything except the power-on reset. The control word is cleared by every reset kind, but the status word is untouched by a standby exit. Reads of the status word are stretched by a fixed number of wait cycles. The status value is captured in the first cycle of the read and returned when ready rises.

Top module: `pwr_regs`

## Requirements
- R1: After a power-on reset both registers read 0x0000_0000, provided the detector and reference inputs are low.
- R2: In the control word, bits 0 (low-power regulator), 1 (power-down deep sleep), 4 (detector enable), 7:5 (detector level), 8 (backup write enable) and 11:9 (converter enables 1 to 3) read back as written and drive the matching output ports. Bits 31:12 read 0.
- R3: Control bits 2 (clear wakeup) and 3 (clear standby) always read 0. Writing 1 to bit 3 clears the standby flag at the write edge.
- R4: Writing 1 to control bit 2 clears the wakeup flag (status bit 0) two clock cycles after the write edge, not one.
- R5: A rising edge on a wakeup pin whose enable (status bit 8+i for pin i) is 1 sets the wakeup flag. An edge on a disabled pin has no effect.
- R6: Setting a pin enable while that pin is already high sets the wakeup flag. A pin that stays high causes no further event after a clear.
- R7: The standby-set strobe sets status bit 1. The flag survives system and standby-exit resets and is cleared only by the power-on reset or by the clear-standby command.
- R8: A standby-exit reset clears the control word and its output ports, and leaves the status word (flags and pin enables) unchanged.
- R9: A system reset clears the control word, the wakeup flag and the pin enables.
- R10: Control accesses and all writes complete with ready in the request cycle. A status read holds ready low for RD_WAIT cycles first.
- R11: Writes are accepted only with byte enables 4'b1111, 4'b0011 or 4'b1100, and other patterns change nothing. Status bits 0 to 3 are read-only. Unused status bits read 0.
- R12: Status bit 2 shows the detector input while detector enable is 1 and reads 0 otherwise. Status bit 3 shows the reference-ready input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_por | input | 1 | Power-on/power-down reset, synchronous, active high |
| rst_sys | input | 1 | System reset, synchronous, active high |
| rst_stby | input | 1 | Standby-exit reset, synchronous, active high |
| bus_req | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while ready is high |
| bus_ready | output | 1 | Access completes at the next edge |
| wk_pin | input | 3 | Wakeup pins |
| sb_set | input | 1 | Standby-entered strobe |
| det_in | input | 1 | Supply detector comparator output |
| ref_rdy | input | 1 | Internal reference ready |
| lp_reg | output | 1 | Low-power regulator in deep sleep |
| pdds | output | 1 | Power-down in deep sleep |
| det_en | output | 1 | Detector enable |
| det_lvl | output | 3 | Detector threshold select |
| bkp_we | output | 1 | Backup-domain write permission |
| conv_en | output | 3 | Converter enables |

## Verification
The bench builds the unit with RD_WAIT set to 3, so the status wait count it measures differs from the default. With this value a status read started in the cycle after a clear-wakeup write captures the flag before the delayed clear lands. That makes the difference between a one-cycle and a two-cycle clear visible at the bus. WUF_CLR_DLY stays at 2 and ADDR_W at 4, so an unmapped address 0x8 could also be reached.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_WK   = 3;
    localparam int NUM_CONV = 3;
    localparam int LVL_W    = 3;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;

    // control word bit positions
    localparam int C_LPREG = 0;
    localparam int C_PDDS  = 1;
    localparam int C_CWU   = 2;
    localparam int C_CSB   = 3;
    localparam int C_DETEN = 4;
    localparam int C_LVL   = 5;
    localparam int C_BKPWE = C_LVL + LVL_W;
    localparam int C_CONV  = C_BKPWE + 1;

    // status word bit positions
    localparam int S_WUF  = 0;
    localparam int S_SBF  = 1;
    localparam int S_DET  = 2;
    localparam int S_REF  = 3;
    localparam int S_WKEN = 8;

    typedef struct packed {
        logic [NUM_CONV-1:0] conv_en;
        logic                bkp_we;
        logic [LVL_W-1:0]    det_lvl;
        logic                det_en;
        logic                pdds;
        logic                lp_reg;
    } ctrl_t;

    typedef struct packed {
        logic [NUM_WK-1:0] wk_en;
        logic              sbf;
        logic              wuf;
    } stat_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } sel_e;

    function automatic logic be_ok(input logic [3:0] be);
        return (be == 4'b1111) || (be == 4'b0011) || (be == 4'b1100);
    endfunction

    function automatic logic [DATA_W-1:0] merge_be(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [3:0]        be);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < 4; i++) begin
            r[i*8 +: 8] = be[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[C_LPREG]            = c.lp_reg;
        w[C_PDDS]             = c.pdds;
        w[C_DETEN]            = c.det_en;
        w[C_LVL +: LVL_W]     = c.det_lvl;
        w[C_BKPWE]            = c.bkp_we;
        w[C_CONV +: NUM_CONV] = c.conv_en;
        return w;
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.lp_reg  = w[C_LPREG];
        c.pdds    = w[C_PDDS];
        c.det_en  = w[C_DETEN];
        c.det_lvl = w[C_LVL +: LVL_W];
        c.bkp_we  = w[C_BKPWE];
        c.conv_en = w[C_CONV +: NUM_CONV];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input stat_t s, input logic det,
                                                    input logic rdy);
        logic [DATA_W-1:0] w;
        w = '0;
        w[S_WUF]              = s.wuf;
        w[S_SBF]              = s.sbf;
        w[S_DET]              = det;
        w[S_REF]              = rdy;
        w[S_WKEN +: NUM_WK]   = s.wk_en;
        return w;
    endfunction

endpackage

// File: rtl/pwr_bus_if.sv
module pwr_bus_if
    import pwr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int RD_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    output sel_e              sel_o,
    output logic              ready_o,
    output logic              wr_ctrl_o,
    output logic              wr_stat_o,
    output logic              snap_o
);
    localparam int CNT_W = (RD_WAIT < 1) ? 1 : $clog2(RD_WAIT + 1);
    localparam logic [CNT_W-1:0] WAIT_V = CNT_W'(RD_WAIT);

    logic [CNT_W-1:0] cnt_q;
    logic             stat_rd;
    logic             wr_ok;

    always_comb begin
        if (bus_addr == ADDR_W'(OFS_CTRL))      sel_o = SEL_CTRL;
        else if (bus_addr == ADDR_W'(OFS_STAT)) sel_o = SEL_STAT;
        else                                    sel_o = SEL_NONE;
    end

    assign stat_rd = bus_req && !bus_wr && (sel_o == SEL_STAT);
    assign ready_o = stat_rd ? (cnt_q == WAIT_V) : bus_req;
    assign snap_o  = stat_rd && (cnt_q == '0);

    assign wr_ok     = bus_req && bus_wr && be_ok(bus_be);
    assign wr_ctrl_o = wr_ok && (sel_o == SEL_CTRL);
    assign wr_stat_o = wr_ok && (sel_o == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (stat_rd && !ready_o) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
    import pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [3:0]        be,
    output ctrl_t             ctrl_q,
    output logic              clr_wu_cmd,
    output logic              clr_sb_cmd
);
    logic [DATA_W-1:0] merged;

    // clear-command bits are never stored, so the old word carries 0 there
    assign merged     = merge_be(ctrl_word(ctrl_q), wdata, be);
    assign clr_wu_cmd = wr_en && merged[C_CWU];
    assign clr_sb_cmd = wr_en && merged[C_CSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_from_word(merged);
        end
    end
endmodule

// File: rtl/pwr_stat_reg.sv
module pwr_stat_reg
    import pwr_pkg::*;
#(
    parameter int WUF_CLR_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_por,
    input  logic              rst_sys,
    input  logic [NUM_WK-1:0] wk_pin,
    input  logic              sb_set,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [3:0]        be,
    input  logic              clr_wu_cmd,
    input  logic              clr_sb_cmd,
    output stat_t             stat_q,
    output logic              wk_evt
);
    logic                   rst_wk;
    logic [NUM_WK-1:0]      gated;
    logic [NUM_WK-1:0]      gated_q;
    logic [NUM_WK-1:0]      hit;
    logic [WUF_CLR_DLY-1:0] clr_sh;
    logic                   wuf_clr;
    logic [DATA_W-1:0]      merged;

    assign rst_wk = rst_por || rst_sys;

    // edge of (enable AND pin): covers a pin rising and an enable set on a high pin
    for (genvar i = 0; i < NUM_WK; i++) begin : g_wk
        assign gated[i] = stat_q.wk_en[i] & wk_pin[i];
        always_ff @(posedge clk) begin
            if (rst_wk) gated_q[i] <= 1'b0;
            else        gated_q[i] <= gated[i];
        end
        assign hit[i] = gated[i] & ~gated_q[i];
    end

    assign wk_evt = |hit;

    always_ff @(posedge clk) begin
        if (rst_wk) clr_sh <= '0;
        else        clr_sh <= (clr_sh << 1) | WUF_CLR_DLY'(clr_wu_cmd);
    end
    assign wuf_clr = clr_sh[WUF_CLR_DLY-1];

    assign merged = merge_be(stat_word(stat_q, 1'b0, 1'b0), wdata, be);

    always_ff @(posedge clk) begin
        if (rst_wk) begin
            stat_q.wuf <= 1'b0;
        end else if (wk_evt) begin
            stat_q.wuf <= 1'b1;
        end else if (wuf_clr) begin
            stat_q.wuf <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_por) begin
            stat_q.sbf <= 1'b0;
        end else if (sb_set) begin
            stat_q.sbf <= 1'b1;
        end else if (clr_sb_cmd) begin
            stat_q.sbf <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_wk) begin
            stat_q.wk_en <= '0;
        end else if (wr_en) begin
            stat_q.wk_en <= merged[S_WKEN +: NUM_WK];
        end
    end
endmodule

// File: rtl/pwr_regs.sv
module pwr_regs
    import pwr_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int RD_WAIT     = 2,
    parameter int WUF_CLR_DLY = 2
) (
    input  logic                clk,
    input  logic                rst_por,
    input  logic                rst_sys,
    input  logic                rst_stby,
    input  logic                bus_req,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [3:0]          bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ready,
    input  logic [NUM_WK-1:0]   wk_pin,
    input  logic                sb_set,
    input  logic                det_in,
    input  logic                ref_rdy,
    output logic                lp_reg,
    output logic                pdds,
    output logic                det_en,
    output logic [LVL_W-1:0]    det_lvl,
    output logic                bkp_we,
    output logic [NUM_CONV-1:0] conv_en
);
    sel_e              sel;
    logic              wr_ctrl;
    logic              wr_stat;
    logic              snap;
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic              clr_wu_cmd;
    logic              clr_sb_cmd;
    logic              wk_evt;
    logic [DATA_W-1:0] stat_live;
    logic [DATA_W-1:0] stat_snap;
    logic [DATA_W-1:0] stat_rd;

    pwr_bus_if #(.ADDR_W(ADDR_W), .RD_WAIT(RD_WAIT)) u_bus (
        .clk       (clk),
        .rst       (rst_por || rst_sys),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .sel_o     (sel),
        .ready_o   (bus_ready),
        .wr_ctrl_o (wr_ctrl),
        .wr_stat_o (wr_stat),
        .snap_o    (snap)
    );

    pwr_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst_por || rst_sys || rst_stby),
        .wr_en      (wr_ctrl),
        .wdata      (bus_wdata),
        .be         (bus_be),
        .ctrl_q     (ctrl_q),
        .clr_wu_cmd (clr_wu_cmd),
        .clr_sb_cmd (clr_sb_cmd)
    );

    pwr_stat_reg #(.WUF_CLR_DLY(WUF_CLR_DLY)) u_stat (
        .clk        (clk),
        .rst_por    (rst_por),
        .rst_sys    (rst_sys),
        .wk_pin     (wk_pin),
        .sb_set     (sb_set),
        .wr_en      (wr_stat),
        .wdata      (bus_wdata),
        .be         (bus_be),
        .clr_wu_cmd (clr_wu_cmd),
        .clr_sb_cmd (clr_sb_cmd),
        .stat_q     (stat_q),
        .wk_evt     (wk_evt)
    );

    assign stat_live = stat_word(stat_q, det_in && ctrl_q.det_en, ref_rdy);

    always_ff @(posedge clk) begin
        if (rst_por || rst_sys) stat_snap <= '0;
        else if (snap)          stat_snap <= stat_live;
    end

    if (RD_WAIT == 0) begin : g_rd_live
        assign stat_rd = stat_live;
    end else begin : g_rd_snap
        assign stat_rd = stat_snap;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: bus_rdata = ctrl_word(ctrl_q);
            SEL_STAT: bus_rdata = stat_rd;
            default:  bus_rdata = '0;
        endcase
    end

    assign lp_reg  = ctrl_q.lp_reg;
    assign pdds    = ctrl_q.pdds;
    assign det_en  = ctrl_q.det_en;
    assign det_lvl = ctrl_q.det_lvl;
    assign bkp_we  = ctrl_q.bkp_we;
    assign conv_en = ctrl_q.conv_en;
endmodule

// File: rtl/pwr_regs_chk.sv
module pwr_regs_chk
    import pwr_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int RD_WAIT     = 2,
    parameter int WUF_CLR_DLY = 2
) (
    input logic              clk,
    input logic              rst_por,
    input logic              rst_sys,
    input logic              rst_stby,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready,
    input ctrl_t             ctrl_q,
    input stat_t             stat_q,
    input logic              clr_wu_cmd,
    input logic              clr_sb_cmd,
    input logic              wk_evt
);
    logic is_ctrl;
    logic is_stat;
    int   wcnt;
    int   since_clr;

    assign is_ctrl = bus_addr == ADDR_W'(OFS_CTRL);
    assign is_stat = bus_addr == ADDR_W'(OFS_STAT);

    always_ff @(posedge clk) begin
        if (rst_por || rst_sys) begin
            wcnt      <= 0;
            since_clr <= WUF_CLR_DLY;
        end else begin
            wcnt <= (bus_req && !bus_wr && is_stat && !bus_ready) ? wcnt + 1 : 0;
            if (clr_wu_cmd)                since_clr <= 0;
            else if (since_clr < WUF_CLR_DLY) since_clr <= since_clr + 1;
        end
    end

    a_r10_ctrl_no_wait: assert property (@(posedge clk) disable iff (rst_por)
        (bus_req && is_ctrl) |-> bus_ready);

    a_r10_stat_wait: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        (bus_req && !bus_wr && is_stat && bus_ready) |-> (wcnt == RD_WAIT));

    a_r3_clear_bits_zero: assert property (@(posedge clk) disable iff (rst_por)
        (bus_req && !bus_wr && is_ctrl) |-> (bus_rdata[3:2] == 2'b00 && bus_rdata[31:12] == '0));

    a_r4_wuf_not_early: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        ((WUF_CLR_DLY > 1) && clr_wu_cmd && stat_q.wuf && since_clr >= WUF_CLR_DLY)
        |=> stat_q.wuf);

    a_r5_evt_sets_wuf: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        wk_evt |=> stat_q.wuf);

    a_r7_sbf_hold: assert property (@(posedge clk) disable iff (rst_por)
        (stat_q.sbf && !clr_sb_cmd) |=> stat_q.sbf);

    a_r8_ctrl_cleared: assert property (@(posedge clk) disable iff (rst_por)
        (rst_stby || rst_sys) |=> (ctrl_q == '0));

    a_r9_sys_clears_wk: assert property (@(posedge clk) disable iff (rst_por)
        rst_sys |=> (stat_q.wk_en == '0 && !stat_q.wuf));
endmodule

bind pwr_regs pwr_regs_chk #(
    .ADDR_W      (ADDR_W),
    .RD_WAIT     (RD_WAIT),
    .WUF_CLR_DLY (WUF_CLR_DLY)
) i_pwr_regs_chk (
    .clk        (clk),
    .rst_por    (rst_por),
    .rst_sys    (rst_sys),
    .rst_stby   (rst_stby),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .ctrl_q     (ctrl_q),
    .stat_q     (stat_q),
    .clr_wu_cmd (clr_wu_cmd),
    .clr_sb_cmd (clr_sb_cmd),
    .wk_evt     (wk_evt)
);

// File: tb/test_pwr_regs.sv
`timescale 1ns/1ps
module test_pwr_regs;
    import pwr_pkg::*;

    localparam int ADDR_W  = 4;
    localparam int RD_WAIT = 3;
    localparam int CLR_DLY = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_por = 1'b1, rst_sys = 1'b0, rst_stby = 1'b0;
    logic bus_req = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0] bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_ready;
    logic [2:0] wk_pin = '0;
    logic sb_set = 1'b0, det_in = 1'b0, ref_rdy = 1'b0;
    logic lp_reg, pdds, det_en, bkp_we;
    logic [2:0] det_lvl, conv_en;

    pwr_regs #(.ADDR_W(ADDR_W), .RD_WAIT(RD_WAIT), .WUF_CLR_DLY(CLR_DLY)) i_pwr_regs (
        .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys), .rst_stby(rst_stby),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .wk_pin(wk_pin), .sb_set(sb_set), .det_in(det_in), .ref_rdy(ref_rdy),
        .lp_reg(lp_reg), .pdds(pdds), .det_en(det_en), .det_lvl(det_lvl),
        .bkp_we(bkp_we), .conv_en(conv_en)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   waits;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected read value when a read completes
    always @(negedge clk) begin
        if (bus_req && !bus_wr && bus_ready) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underrun", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, bus_rdata, e.exp);
            end
        end
    end

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                      input string tag, output int nw);
        exp_t e;
        e.exp = exp;
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk); #1;
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        nw = 0;
        forever begin
            @(negedge clk);
            if (bus_ready) break;
            nw++;
        end
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic rdc(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        int nw;
        rd(a, exp, tag, nw);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(posedge clk); #1;
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        @(posedge clk); #1;
        bus_req = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic pulse(input int which);
        @(posedge clk); #1;
        case (which)
            0: rst_por  = 1'b1;
            1: rst_sys  = 1'b1;
            2: rst_stby = 1'b1;
            default: sb_set = 1'b1;
        endcase
        @(posedge clk); #1;
        rst_por = 1'b0; rst_sys = 1'b0; rst_stby = 1'b0; sb_set = 1'b0;
    endtask

    task automatic set_pin(input int i, input logic v);
        @(posedge clk); #1;
        wk_pin[i] = v;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_por = 1'b0;

        // R1 reset state
        rdc(A_CTRL, 32'h0, "R1 ctrl after por");
        rdc(A_STAT, 32'h0, "R1 stat after por");

        // R2 / R3 full write, clear bits and reserved read 0
        wr(A_CTRL, 32'hFFFF_FFFF, 4'hF);
        rdc(A_CTRL, 32'h0000_0FF3, "R2 R3 ctrl all ones");
        check("R2 det_lvl port", {29'b0, det_lvl}, 32'd7);
        check("R2 conv_en port", {29'b0, conv_en}, 32'd7);
        check("R2 single ports", {28'b0, lp_reg, pdds, det_en, bkp_we}, 32'hF);

        // R11 byte-enable rules
        wr(A_CTRL, 32'h0, 4'b0001);
        rdc(A_CTRL, 32'h0000_0FF3, "R11 byte write ignored");
        wr(A_CTRL, 32'h0000_0A51, 4'b0011);
        rdc(A_CTRL, 32'h0000_0A51, "R11 low half write");
        wr(A_CTRL, 32'hFFFF_0000, 4'b1100);
        rdc(A_CTRL, 32'h0000_0A51, "R11 high half reserved");

        // R12 detector and reference mirror
        det_in = 1'b1; ref_rdy = 1'b1;
        rdc(A_STAT, 32'h0000_000C, "R12 det enabled");
        wr(A_CTRL, 32'h0000_0A41, 4'hF);
        rdc(A_STAT, 32'h0000_0008, "R12 det gated off");
        det_in = 1'b0; ref_rdy = 1'b0;

        // R10 wait cycles
        rd(A_STAT, 32'h0, "R10 stat data", waits);
        check("R10 stat wait count", waits, RD_WAIT);
        rd(A_CTRL, 32'h0000_0A41, "R10 ctrl data", waits);
        check("R10 ctrl wait count", waits, 0);

        // R11 status flags read-only
        wr(A_STAT, 32'hFFFF_FFFF, 4'hF);
        rdc(A_STAT, 32'h0000_0700, "R11 stat only enables");
        wr(A_STAT, 32'h0000_0100, 4'hF);

        // R5 enabled vs disabled pin
        set_pin(1, 1'b1);
        rdc(A_STAT, 32'h0000_0100, "R5 disabled pin ignored");
        set_pin(0, 1'b1);
        rdc(A_STAT, 32'h0000_0101, "R5 enabled pin edge");
        set_pin(0, 1'b0);
        set_pin(1, 1'b0);

        // R4 delayed wakeup clear (snapshot taken one cycle after write)
        wr(A_CTRL, 32'h0000_0A45, 4'hF);
        rdc(A_STAT, 32'h0000_0101, "R4 flag still set at write+1");
        rdc(A_STAT, 32'h0000_0100, "R4 flag cleared later");
        rdc(A_CTRL, 32'h0000_0A41, "R3 clear-wakeup reads 0");

        // R6 enable on high pin
        set_pin(2, 1'b1);
        rdc(A_STAT, 32'h0000_0100, "R6 disabled high pin");
        wr(A_STAT, 32'h0000_0500, 4'hF);
        rdc(A_STAT, 32'h0000_0501, "R6 enable while high");
        wr(A_CTRL, 32'h0000_0A45, 4'hF);
        repeat (3) @(posedge clk);
        rdc(A_STAT, 32'h0000_0500, "R6 no repeat event");

        // R7 / R3 standby flag
        pulse(3);
        rdc(A_STAT, 32'h0000_0502, "R7 standby set");
        wr(A_CTRL, 32'h0000_0A49, 4'hF);
        rdc(A_STAT, 32'h0000_0500, "R3 clear standby");
        rdc(A_CTRL, 32'h0000_0A41, "R3 clear-standby reads 0");
        pulse(3);

        // R8 standby-exit reset
        set_pin(0, 1'b1);
        rdc(A_STAT, 32'h0000_0503, "R8 pre stat");
        pulse(2);
        rdc(A_CTRL, 32'h0, "R8 ctrl cleared");
        check("R8 ports cleared", {23'b0, conv_en, bkp_we, det_lvl, det_en, pdds, lp_reg}, 32'h0);
        rdc(A_STAT, 32'h0000_0503, "R8 stat kept");

        // R9 system reset, R7 survives it
        wr(A_CTRL, 32'h0000_0100, 4'hF);
        pulse(1);
        rdc(A_CTRL, 32'h0, "R9 ctrl cleared");
        rdc(A_STAT, 32'h0000_0002, "R9 R7 only standby kept");

        // R7 power-on reset clears standby flag
        pulse(0);
        rdc(A_STAT, 32'h0, "R7 por clears standby");

        repeat (2) @(posedge clk);
        check("scoreboard drained", sb_q.size(), 0);
        finish_run();
    end
endmodule